// File: doc/BRIEF.md
# Startup and Auto-Restart Supervisor

This block sequences the life of an off-line switching converter through power-up, soft-start, steady run, protective shutdown and hiccup restart. The analog parts around it (the high-voltage startup current source, the supply capacitor and the threshold comparators) appear only as digital flags. The block reads these flags and decides three things. It decides when the startup source charges the supply and at which of its two current levels. It decides when the power switch may operate. During each start it raises a current-limit code from zero to full scale in equal steps.

After a normal loss of supply, the block waits for the supply to drain to a low restart level and then recharges at the normal current. After any fault (overload, over-temperature or an externally qualified fault), it holds switching off for as long as the supply stays above the undervoltage level. It then waits for the restart level and recharges at the reduced current, so that restart attempts stay far apart. A mains brown-out only pauses switching, with no latch, and a soft-start follows once the input has risen past the upper hysteresis level.

Top module: `startup_supervisor`

## Requirements
- R1: `src_en` is 1 only in the charge phase, and only while `drain_ok` is 1. It is 0 in every other phase.
- R2: In the charge phase, `vdd_on`=1 (with `br_below`=0) starts switching at the next clock edge: `sw_en`=1, `src_en`=0, `ilim_code`=0.
- R3: During soft-start, `ilim_code` rises by exactly 1 every STEP_CYC clock cycles until it reaches 2^CODE_W-1. It then stays at that value while switching continues.
- R4: While switching, `vdd_uv`=1 stops switching at the next edge. The source stays off until `vdd_rst`=1, and is then enabled at the normal current (`low_chg`=0).
- R5: While switching, `olp_trip`, `therm_trip` or `ext_fault` at 1 stops switching at the next edge and sets `low_chg`=1. After a later `vdd_uv` and then `vdd_rst`, the source is enabled with `low_chg`=1.
- R6: After a fault, `src_en` and `sw_en` stay 0 while the supply stays above undervoltage. This holds even if `vdd_rst` is 1 and the fault inputs have returned to 0.
- R7: While switching, `br_below`=1 stops switching at the next edge and does not set `low_chg`. Switching stays off while both brown-out flags are 0. A pulse on `br_above` restarts switching with `ilim_code`=0.
- R8: In a brown-out pause, `vdd_uv`=1 returns the block directly to the charge phase without waiting for `vdd_rst`. A following `vdd_on` while `br_below`=1 does not start switching.
- R9: When several stop conditions arrive in the same cycle, undervoltage wins over a fault, and a fault wins over brown-out.
- R10: `low_chg` returns to 0 at the edge where switching starts again after a fault restart.
- R11: After reset, the block is in the charge phase with `sw_en`=0, `ilim_code`=0 and `low_chg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drain_ok | input | 1 | Bulk drain voltage is above the start level |
| vdd_on | input | 1 | Supply has reached the turn-on level |
| vdd_uv | input | 1 | Supply is below the undervoltage level |
| vdd_rst | input | 1 | Supply is below the low restart level |
| br_below | input | 1 | Brown-out input is below its falling threshold |
| br_above | input | 1 | Brown-out input is above threshold plus hysteresis |
| olp_trip | input | 1 | Overload feedback threshold reached |
| therm_trip | input | 1 | Thermal shutdown asserted |
| ext_fault | input | 1 | Other qualified fault (e.g. overvoltage, second-level overcurrent) |
| src_en | output | 1 | Startup current source enable |
| low_chg | output | 1 | 1 selects the reduced charge current |
| sw_en | output | 1 | Power switch operation allowed |
| ilim_code | output | CODE_W | Current-limit ramp code, 0 when not switching |

## Verification
The assertions assume that the comparator flags behave like real supply levels. `vdd_on` and `vdd_uv` are never 1 together, and `br_below` and `br_above` are never 1 together. They also assume that no flag changes inside a clock cycle in a way the block could see twice. The bench drives every flag on the falling clock edge. It holds each flag for exactly the cycles a scenario needs and returns it to 0 before the next step, so the contradictory pairs never occur. Results are read on the following falling edge, one register stage after the stimulus.

// File: rtl/startup_supervisor.sv
module startup_supervisor #(
  parameter int CODE_W   = 4,
  parameter int STEP_CYC = 28333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drain_ok,
  input  logic              vdd_on,
  input  logic              vdd_uv,
  input  logic              vdd_rst,
  input  logic              br_below,
  input  logic              br_above,
  input  logic              olp_trip,
  input  logic              therm_trip,
  input  logic              ext_fault,
  output logic              src_en,
  output logic              low_chg,
  output logic              sw_en,
  output logic [CODE_W-1:0] ilim_code
);
  localparam int CNT_W = $clog2(STEP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  typedef enum logic [2:0] {ST_CHARGE, ST_SOFT, ST_RUN, ST_BROWN, ST_LATCH, ST_WAIT} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] code;
  logic              after_flt;
  logic              any_flt;

  assign any_flt   = olp_trip | therm_trip | ext_fault;
  assign sw_en     = (st == ST_SOFT) || (st == ST_RUN);
  assign src_en    = (st == ST_CHARGE) && drain_ok;
  assign low_chg   = after_flt;
  assign ilim_code = sw_en ? code : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_CHARGE;
      cnt       <= '0;
      code      <= '0;
      after_flt <= 1'b0;
    end else begin
      case (st)
        ST_CHARGE:
          if (vdd_on) begin
            cnt  <= '0;
            code <= '0;
            if (br_below) st <= ST_BROWN;
            else begin
              st        <= ST_SOFT;
              after_flt <= 1'b0;
            end
          end
        ST_SOFT, ST_RUN:
          if (vdd_uv) begin
            st        <= ST_WAIT;
            after_flt <= 1'b0;
          end else if (any_flt) begin
            st        <= ST_LATCH;
            after_flt <= 1'b1;
          end else if (br_below) begin
            st <= ST_BROWN;
          end else if (st == ST_SOFT) begin
            if (cnt == CNT_LAST) begin
              cnt  <= '0;
              code <= code + 1'b1;
              if (code == CODE_MAX - 1'b1) st <= ST_RUN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        ST_BROWN:
          if (vdd_uv) st <= ST_CHARGE;
          else if (br_above) begin
            st        <= ST_SOFT;
            cnt       <= '0;
            code      <= '0;
            after_flt <= 1'b0;
          end
        ST_LATCH:
          if (vdd_uv) st <= ST_WAIT;
        ST_WAIT:
          if (vdd_rst) st <= ST_CHARGE;
        default: st <= ST_CHARGE;
      endcase
    end
  end

  AST_SRC_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    src_en |-> drain_ok); // R1
  AST_SRC_SW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_en && sw_en)); // R2
  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en)) |-> (ilim_code == $past(ilim_code) ||
                                 ilim_code == $past(ilim_code) + 1'b1)); // R3
  AST_UV_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && vdd_uv) |=> (!sw_en && !low_chg)); // R4
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !vdd_uv && any_flt) |=> (!sw_en && low_chg)); // R5
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && !src_en && low_chg && !vdd_uv && $past(sw_en)) |=> (!sw_en && !src_en)); // R6
endmodule

// File: tb/sim_startup_supervisor.sv
module sim_startup_supervisor;
  localparam int CW = 3;
  localparam int SC = 3;
  localparam int RAMP = SC * ((1 << CW) - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic drain_ok = 0, vdd_on = 0, vdd_uv = 0, vdd_rst = 0;
  logic br_below = 0, br_above = 0, olp_trip = 0, therm_trip = 0, ext_fault = 0;
  logic src_en, low_chg, sw_en;
  logic [CW-1:0] ilim_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  startup_supervisor #(.CODE_W(CW), .STEP_CYC(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .drain_ok(drain_ok), .vdd_on(vdd_on), .vdd_uv(vdd_uv),
    .vdd_rst(vdd_rst), .br_below(br_below), .br_above(br_above), .olp_trip(olp_trip),
    .therm_trip(therm_trip), .ext_fault(ext_fault), .src_en(src_en), .low_chg(low_chg),
    .sw_en(sw_en), .ilim_code(ilim_code));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_on;
    vdd_on = 1; tick(1); vdd_on = 0;
  endtask

  task automatic to_run;
    pulse_on(); tick(RAMP);
  endtask

  task automatic t_reset;
    tick(1);
    chk("R11 sw_en", sw_en, 0); chk("R11 code", ilim_code, 0); chk("R11 low_chg", low_chg, 0);
    chk("R1 src without drain", src_en, 0);
    drain_ok = 1; #1;
    chk("R1 src with drain", src_en, 1);
  endtask

  task automatic t_start_ramp;
    pulse_on();
    chk("R2 sw_en", sw_en, 1); chk("R2 src_en", src_en, 0); chk("R2 code", ilim_code, 0);
    for (int k = 1; k <= RAMP + 6; k++) begin
      tick(1);
      chk("R3 ramp code", ilim_code, (k / SC > (1 << CW) - 1) ? (1 << CW) - 1 : k / SC);
    end
    chk("R3 still switching", sw_en, 1);
  endtask

  task automatic t_uv;
    vdd_uv = 1; tick(1); vdd_uv = 0;
    chk("R4 sw off", sw_en, 0);
    tick(4);
    chk("R4 src waits", src_en, 0);
    vdd_rst = 1; tick(1); vdd_rst = 0;
    chk("R4 src on", src_en, 1); chk("R4 normal current", low_chg, 0);
  endtask

  task automatic t_fault(input int which);
    to_run();
    if (which == 0) olp_trip = 1; else if (which == 1) therm_trip = 1; else ext_fault = 1;
    tick(1);
    olp_trip = 0; therm_trip = 0; ext_fault = 0;
    chk("R5 sw off", sw_en, 0); chk("R5 low_chg", low_chg, 1);
    vdd_rst = 1; tick(3); vdd_rst = 0;
    chk("R6 latched src", src_en, 0); chk("R6 latched sw", sw_en, 0);
    vdd_uv = 1; tick(1); vdd_uv = 0;
    vdd_rst = 1; tick(1); vdd_rst = 0;
    chk("R5 src on", src_en, 1); chk("R5 reduced current", low_chg, 1);
    pulse_on();
    chk("R10 restart sw", sw_en, 1); chk("R10 low_chg cleared", low_chg, 0);
    tick(RAMP);
  endtask

  task automatic t_brown;
    tick(2);
    br_below = 1; tick(1); br_below = 0;
    chk("R7 sw off", sw_en, 0); chk("R7 no latch", low_chg, 0);
    tick(4);
    chk("R7 stays off", sw_en, 0); chk("R7 src off", src_en, 0);
    br_above = 1; tick(1); br_above = 0;
    chk("R7 resume", sw_en, 1); chk("R7 code restart", ilim_code, 0);
    tick(RAMP);
  endtask

  task automatic t_brown_uv;
    br_below = 1; tick(1);
    chk("R8 paused", sw_en, 0);
    vdd_uv = 1; tick(1); vdd_uv = 0;
    chk("R8 direct charge", src_en, 1);
    pulse_on();
    chk("R8 no start in brown", sw_en, 0);
    br_below = 0; br_above = 1; tick(1); br_above = 0;
    chk("R8 resume", sw_en, 1);
    tick(RAMP);
  endtask

  task automatic t_prio;
    vdd_uv = 1; olp_trip = 1; tick(1); vdd_uv = 0; olp_trip = 0;
    chk("R9 uv beats fault", low_chg, 0);
    vdd_rst = 1; tick(1); vdd_rst = 0;
    chk("R9 uv path src", src_en, 1);
    to_run();
    ext_fault = 1; br_below = 1; tick(1); ext_fault = 0; br_below = 0;
    chk("R9 fault beats brown", low_chg, 1);
    br_above = 1; tick(2); br_above = 0;
    chk("R9 latched not brown", sw_en, 0);
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    t_reset();
    t_start_ramp();
    t_uv();
    for (int w = 0; w < 3; w++) t_fault(w);
    t_brown();
    t_brown_uv();
    t_prio();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule